// File: doc/BRIEF.md
# Return Address Ring Stack with Stall Release Tracker

This block predicts function return targets for an instruction fetch front end. A call pushes its return address, and a return pops the most recent address in the same cycle it asks. The storage is a circular buffer that never reports full. When it is at capacity, a new push overwrites the oldest address, so the front end never waits on the stack. A pop on an empty stack returns no valid address. The front end then handles that return as an unpredicted indirect jump and stalls until the jump resolves.

A small token counter sits beside the stack and decides when such a stall may end. Every pop that delivers a valid address adds one token. Every executed-indirect-jump handshake from the back end consumes one token. A handshake that arrives while no tokens are outstanding belongs to the stalled jump and raises the release output. This stops an indirect jump that was already predicted by the stack from ending a stall that belongs to a later jump. A front-end flush clears the tokens and leaves the stack contents alone.

Top module: `ret_addr_ring`

## Requirements
- R1: After reset, `empty_o` is 1. No tokens are outstanding, so a handshake in the first cycle raises `stall_release_o`.
- R2: Pushed addresses come back in last-in-first-out order. `pop_valid_o` and `pop_addr_o` answer a pop in the same cycle. `empty_o` is 1 exactly when the stack holds no entries.
- R3: A push is never refused. A push on a stack that holds DEPTH entries (default 8) discards the oldest entry. After N > DEPTH pushes, DEPTH pops return the last DEPTH addresses, and then the stack is empty.
- R4: A pop on an empty stack gives `pop_valid_o` = 0. It leaves the stack empty and adds no token.
- R5: When push and pop arrive in the same cycle on a non-empty stack, the pop returns the current top and the new address replaces it. The entry count is unchanged. On an empty stack, the same pair gives an invalid pop and stores the pushed address.
- R6: Every pop with `pop_valid_o` = 1 adds one token to the tracker.
- R7: Each `jalr_done_i` pulse removes one token if any are outstanding. `stall_release_o` is 1 only in a cycle where `jalr_done_i` is 1 and no tokens are outstanding at the start of that cycle.
- R8: `flush_i` clears all tokens, overriding any same-cycle token change. It does not change the stack contents or the entry count.
- R9: The token count saturates at TOK_MAX (default 15). A valid pop at TOK_MAX without a handshake adds nothing, so exactly TOK_MAX handshakes are consumed before one releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Push a return address (call seen) |
| push_addr_i | input | ADDR_W | Return address to store |
| pop_i | input | 1 | Request the predicted return address |
| pop_addr_o | output | ADDR_W | Top address; zero when the pop is invalid |
| pop_valid_o | output | 1 | Pop delivered a valid address this cycle |
| empty_o | output | 1 | Stack holds no entries |
| jalr_done_i | input | 1 | Back end executed an indirect jump (one pulse per jump) |
| flush_i | input | 1 | Front-end flush; clears tokens |
| stall_release_o | output | 1 | The stalled indirect jump has resolved |

## Verification
`pop_addr_o`, `pop_valid_o` and `stall_release_o` are combinational answers to the inputs of the current cycle. The bench drives each cycle's inputs just after the falling edge and samples these three outputs 1 ns later, before the rising edge. Stack contents, `empty_o` and the token count change at the rising edge. The bench updates its reference queue and token count only after the same-cycle samples, so the next cycle's samples see the new state. Directed runs cover overflow, empty pops, swaps, saturation and flush. A long pseudo-random sweep then mixes all five inputs against the reference.

// File: rtl/ret_addr_pkg.sv
package ret_addr_pkg;
  // Stack action selected for one cycle.
  typedef enum logic [1:0] {
    STK_IDLE = 2'b00,
    STK_POP  = 2'b01,
    STK_PUSH = 2'b10,
    STK_SWAP = 2'b11
  } stk_op_e;
endpackage

// File: rtl/ret_ring_stack.sv
module ret_ring_stack
  import ret_addr_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two, pointers wrap naturally
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic              pop_valid_o,
  output logic              empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;   // next free slot
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  top_idx, wr_idx;
  logic              wr_en, has_entry, at_full;
  stk_op_e           op;

  assign has_entry   = (cnt_q != '0);
  assign at_full     = (cnt_q == FULL_CNT);
  assign top_idx     = wr_ptr_q - 1'b1;
  assign empty_o     = !has_entry;
  assign pop_valid_o = pop_i && has_entry;
  assign pop_addr_o  = pop_valid_o ? slot_q[top_idx] : '0;

  always_comb begin
    op       = stk_op_e'({push_i, pop_valid_o});
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    wr_en    = 1'b0;
    wr_idx   = wr_ptr_q;
    unique case (op)
      STK_PUSH: begin
        wr_en    = 1'b1;
        wr_ptr_d = wr_ptr_q + 1'b1;
        // at capacity the bottom moves with the top: oldest entry is lost
        if (!at_full) cnt_d = cnt_q + 1'b1;
      end
      STK_POP: begin
        wr_ptr_d = top_idx;
        cnt_d    = cnt_q - 1'b1;
      end
      STK_SWAP: begin
        wr_en  = 1'b1;
        wr_idx = top_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PTR_W'(g))) slot_q[g] <= push_addr_i;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  assert_push_never_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> !empty_o);
  assert_empty_pop_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |-> !pop_valid_o);
  assert_swap_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o) |=> $stable(cnt_q));
endmodule

// File: rtl/release_token_counter.sv
module release_token_counter #(
  parameter int TOK_MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic token_i,
  input  logic jalr_done_i,
  input  logic flush_i,
  output logic release_o
);
  localparam int TOK_W = $clog2(TOK_MAX + 1);
  localparam logic [TOK_W-1:0] TOK_TOP = TOK_W'(TOK_MAX);

  logic [TOK_W-1:0] tok_q, tok_d;
  logic             take, give, none_left;

  assign none_left = (tok_q == '0);
  assign release_o = jalr_done_i && none_left;
  assign take      = jalr_done_i && !none_left;
  assign give      = token_i && ((tok_q != TOK_TOP) || take);

  always_comb begin
    tok_d = tok_q;
    if (flush_i)           tok_d = '0;
    else if (give && !take) tok_d = tok_q + 1'b1;
    else if (take && !give) tok_d = tok_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (tok_q == '0));
  assert_release_needs_jalr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> jalr_done_i);
  assert_token_adds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (token_i && !jalr_done_i && !flush_i && (tok_q != TOK_TOP)) |=> (tok_q == $past(tok_q) + 1'b1));
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !jalr_done_i && (tok_q == TOK_TOP)) |=> (tok_q == TOK_TOP));
endmodule

// File: rtl/ret_addr_ring.sv
module ret_addr_ring #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int TOK_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic              pop_valid_o,
  output logic              empty_o,
  input  logic              jalr_done_i,
  input  logic              flush_i,
  output logic              stall_release_o
);
  logic pop_hit;

  ret_ring_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .pop_addr_o  (pop_addr_o),
    .pop_valid_o (pop_hit),
    .empty_o     (empty_o)
  );

  release_token_counter #(.TOK_MAX(TOK_MAX)) i_tokens (
    .clk         (clk),
    .rst_n       (rst_n),
    .token_i     (pop_hit),
    .jalr_done_i (jalr_done_i),
    .flush_i     (flush_i),
    .release_o   (stall_release_o)
  );

  assign pop_valid_o = pop_hit;

  assert_first_release_R1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n) && jalr_done_i) |-> stall_release_o);
endmodule

// File: tb/test_ret_addr_ring.sv
module test_ret_addr_ring;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int TMAX  = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0, jalr_done_i = 1'b0, flush_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic          pop_valid_o, empty_o, stall_release_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] ms[$];
  int mtok = 0;

  always #5 clk = ~clk;

  ret_addr_ring #(.DEPTH(DEPTH), .ADDR_W(AW), .TOK_MAX(TMAX)) i_ret_addr_ring (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .pop_valid_o(pop_valid_o),
    .empty_o(empty_o), .jalr_done_i(jalr_done_i), .flush_i(flush_i),
    .stall_release_o(stall_release_o)
  );

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive after falling edge, sample 1 ns later, then update model.
  task automatic step(input bit psh, input logic [AW-1:0] a, input bit pp, input bit jd, input bit fl, input string req);
    bit ev;
    bit take, give;
    @(negedge clk);
    push_i = psh; push_addr_i = a; pop_i = pp; jalr_done_i = jd; flush_i = fl;
    #1;
    ev = pp && (ms.size() > 0);
    check(empty_o == (ms.size() == 0), {req, " R2 empty"}, AW'(empty_o), AW'(ms.size() == 0));
    check(pop_valid_o == ev, {req, " R4 valid"}, AW'(pop_valid_o), AW'(ev));
    if (ev) check(pop_addr_o == ms[$], {req, " R2 addr"}, pop_addr_o, ms[$]);
    check(stall_release_o == (jd && mtok == 0), {req, " R7 release"}, AW'(stall_release_o), AW'(jd && mtok == 0));
    take = jd && (mtok > 0);
    give = ev && ((mtok < TMAX) || take);
    if (ev) begin
      if (psh) ms[$] = a;
      else void'(ms.pop_back());
    end else if (psh) begin
      if (ms.size() == DEPTH) void'(ms.pop_front());
      ms.push_back(a);
    end
    if (fl) mtok = 0;
    else if (give && !take) mtok++;
    else if (take && !give) mtok--;
  endtask

  task automatic idle(input string req);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, first handshake releases
    #1;
    check(empty_o == 1'b1, "R1 empty after reset", AW'(empty_o), 1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R1 first jalr");

    // R2: LIFO order
    for (int i = 1; i <= 5; i++) step(1'b1, AW'(32'h1000 + i * 4), 1'b0, 1'b0, 1'b0, "R2 push");
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R2 pop");
    // R4: pop on empty, no token added (R6 tokens now 5)
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R4 empty pop");
    // R7: five handshakes consume, sixth releases
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R7 drain");

    // R3: overflow with 12 pushes, then 9 pops
    for (int i = 0; i < 12; i++) step(1'b1, AW'(32'h2000 + i), 1'b0, 1'b0, 1'b0, "R3 push");
    for (int i = 0; i < 9; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R3 pop");
    // R8: flush clears 8 tokens, stack unaffected
    step(1'b1, 32'hAAAA, 1'b0, 1'b0, 1'b1, "R8 flush with push");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R8 release after flush");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R8 stack kept");

    // R5: swap on empty then on non-empty
    step(1'b1, 32'h3000, 1'b1, 1'b0, 1'b0, "R5 swap empty");
    step(1'b1, 32'h3004, 1'b0, 1'b0, 1'b0, "R5 push");
    step(1'b1, 32'h3008, 1'b1, 1'b0, 1'b0, "R5 swap");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R5 pop new top");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R5 pop old");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R5 now empty");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8 flush");

    // R9: 16 valid pops saturate at 15 tokens
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(32'h4000 + i), 1'b0, 1'b0, 1'b0, "R9 fill");
      for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 pop");
    end
    for (int i = 0; i < TMAX + 1; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R9 drain");
    // R6/R7: pop with handshake on zero tokens releases and adds a token
    step(1'b1, 32'h5000, 1'b0, 1'b0, 1'b0, "R6 push");
    step(1'b0, '0, 1'b1, 1'b1, 1'b0, "R6 pop with jalr");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R6 token consumed");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R7 release");

    // Mixed pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 45, AW'($urandom), (r % 3) == 0 || r > 70, (r % 4) == 1, r == 7, "R2 R5 R7 sweep");
    end
    idle("R2 end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule